// File: doc/BRIEF.md
# Mixed Decay Winding Current Chopper

This block controls the current in one bridge winding of a stepping motor by fixed-frequency peak-current chopping. An analog comparator outside the block reports when the sensed winding current has reached the set-point. The block turns that flag into the four gate commands of the H-bridge: high-side left (`u1`), high-side right (`u2`), low-side left (`l1`) and low-side right (`l2`).

Each chop period is a fixed number of sub-clock slots. The block charges the winding until the comparator trips, then holds it in slow decay, then switches to fast decay for the last slots of the period. At the start of the next period it charges again, both to sense the current and to top it up. Charge is held for a minimum sensing time even when the comparator is already tripped. The sign of the set-point selects which bridge diagonal charges. Every change of the applied bridge state passes through a run of all-off cycles. An enable input and a fault input turn the whole bridge off at once.

Top module: `mixed_decay_chopper`

## Requirements
- R1: While reset is asserted, and after it is released with the block not enabled, all four gates are off.
- R2: Chop periods repeat every PERIOD_CLKS = SLOT_CLKS*NUM_SLOTS clocks, counted from the first enabled cycle. Each period begins a new charge attempt.
- R3: Fast decay starts at the mixed-decay point, which is slot NUM_SLOTS-FAST_SLOTS. In gate output time, fast decay appears exactly (NUM_SLOTS-FAST_SLOTS)*SLOT_CLKS clocks after charge appeared in the same period.
- R4: When the comparator trips before the mixed-decay point, charge is followed by slow decay.
- R5: When the comparator trips at or after the mixed-decay point, charge is followed directly by fast decay.
- R6: Charge lasts at least SENSE_CLKS clocks of mode time even when the comparator is high at the start of the period. With SENSE_CLKS > DEAD_CLKS, the charge vector is visible for SENSE_CLKS-DEAD_CLKS cycles.
- R7: For a positive set-point (neg_i=0), the gate vector {u1,u2,l1,l2} is 1001 in charge, 0011 in slow decay and 0110 in fast decay.
- R8: For a negative set-point (neg_i=1), the gate vector {u1,u2,l1,l2} is 0110 in charge, 0011 in slow decay and 1001 in fast decay.
- R9: Every change of the applied gate vector inserts exactly DEAD_CLKS cycles with all gates off. The old vector is never followed directly by a different non-zero vector.
- R10: With en_i low or fault_i high, all gates are off in the same cycle. On release, the period timing restarts, and charge appears DEAD_CLKS+2 clocks after the first enabled clock edge.
- R11: A zero set-point (zero_i=1) holds the bridge in slow decay (0011) while enabled.
- R12: u1 and l1 are never on together, and u2 and l2 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; low forces all gates off |
| fault_i | input | 1 | Fault request; high forces all gates off |
| trip_i | input | 1 | Comparator flag: sensed current at or above the set-point |
| neg_i | input | 1 | Set-point sign, 1 = negative winding current |
| zero_i | input | 1 | Set-point is zero |
| u1_o | output | 1 | High-side gate, left leg |
| u2_o | output | 1 | High-side gate, right leg |
| l1_o | output | 1 | Low-side gate, left leg |
| l2_o | output | 1 | Low-side gate, right leg |

## Verification
The hardest situations to reach are a comparator trip that lands after the mixed-decay point and a trip that is already high when the period starts. Both depend on where the trip falls inside a period that the ports do not show. The bench therefore tracks the period position in its own model and raises trip_i at a chosen position in each period. Directed phases place the trip early, late and at position zero. Random periods then draw the trip point anywhere in the period, including never. Sign flips, zero set-points and one-cycle faults are drawn together with it, so they land mid-period and mid-dead-time.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHARGE = 2'd1,
    MODE_SLOW   = 2'd2,
    MODE_FAST   = 2'd3
  } mode_e;

  typedef struct packed {
    logic u1;
    logic u2;
    logic l1;
    logic l2;
  } gate_t;

  localparam gate_t GATES_OFF = '0;

  // bridge diagonal swaps with the current sign; slow decay is shared
  function automatic gate_t gate_encode(mode_e mode, logic neg);
    gate_t g;
    unique case (mode)
      MODE_CHARGE: g = neg ? gate_t'(4'b0110) : gate_t'(4'b1001);
      MODE_SLOW:   g = gate_t'(4'b0011);
      MODE_FAST:   g = neg ? gate_t'(4'b1001) : gate_t'(4'b0110);
      default:     g = GATES_OFF;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mdc_slot_timer.sv
module mdc_slot_timer #(
  parameter int unsigned SLOT_CLKS  = 20,
  parameter int unsigned NUM_SLOTS  = 5,
  parameter int unsigned FAST_SLOTS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic start_o,
  output logic fast_o
);

  localparam int unsigned CW        = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int unsigned SW        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int unsigned FAST_FROM = NUM_SLOTS - FAST_SLOTS;

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slot_q;
  logic          cnt_wrap;
  logic          slot_wrap;

  assign cnt_wrap  = (cnt_q == CW'(SLOT_CLKS - 1));
  assign slot_wrap = (slot_q == SW'(NUM_SLOTS - 1));

  // timing restarts from slot 0 whenever the bridge is forced off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (cnt_wrap) begin
      cnt_q  <= '0;
      slot_q <= slot_wrap ? '0 : slot_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign start_o = run_i && (cnt_q == '0) && (slot_q == '0);
  assign fast_o  = (slot_q >= SW'(FAST_FROM));

endmodule

// File: rtl/mdc_decay_fsm.sv
module mdc_decay_fsm
  import mdc_pkg::*;
#(
  parameter int unsigned SENSE_CLKS = 20
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  start_i,
  input  logic  fast_i,
  input  logic  trip_i,
  input  logic  zero_i,
  output mode_e mode_o
);

  localparam int unsigned KW = (SENSE_CLKS > 1) ? $clog2(SENSE_CLKS) : 1;

  mode_e         mode_q, mode_d;
  logic [KW-1:0] chg_q;
  logic          sense_done;

  assign sense_done = (chg_q == KW'(SENSE_CLKS - 1));

  always_comb begin
    mode_d = mode_q;
    if (!run_i) begin
      mode_d = MODE_OFF;
    end else if (zero_i) begin
      mode_d = MODE_SLOW;
    end else if (start_i) begin
      mode_d = MODE_CHARGE;
    end else begin
      unique case (mode_q)
        MODE_OFF:    mode_d = MODE_CHARGE;
        MODE_CHARGE: if (trip_i && sense_done) mode_d = fast_i ? MODE_FAST : MODE_SLOW;
        MODE_SLOW:   if (fast_i) mode_d = MODE_FAST;
        default:     mode_d = MODE_FAST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      chg_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (mode_q != MODE_CHARGE) chg_q <= '0;
      else if (!sense_done)      chg_q <= chg_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/mdc_dead_band.sv
module mdc_dead_band
  import mdc_pkg::*;
#(
  parameter int unsigned DEAD_CLKS = 12
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  gate_t req_i,
  output gate_t gate_o
);

  localparam int unsigned DW = $clog2(DEAD_CLKS + 1);

  gate_t         app_q;
  logic [DW-1:0] dead_q;

  // a new request restarts the off window, even mid-window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q  <= GATES_OFF;
      dead_q <= '0;
    end else if (req_i != app_q) begin
      app_q  <= req_i;
      dead_q <= DW'(DEAD_CLKS);
    end else if (dead_q != '0) begin
      dead_q <= dead_q - 1'b1;
    end
  end

  assign gate_o = (run_i && (dead_q == '0)) ? app_q : GATES_OFF;

endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
  import mdc_pkg::*;
#(
  parameter int unsigned SLOT_CLKS  = 20,
  parameter int unsigned NUM_SLOTS  = 5,
  parameter int unsigned FAST_SLOTS = 2,
  parameter int unsigned SENSE_CLKS = 20,
  parameter int unsigned DEAD_CLKS  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fault_i,
  input  logic trip_i,
  input  logic neg_i,
  input  logic zero_i,
  output logic u1_o,
  output logic u2_o,
  output logic l1_o,
  output logic l2_o
);

  logic  run;
  logic  period_start;
  logic  fast_win;
  mode_e mode;
  gate_t gate_req;
  gate_t gate_out;

  assign run = en_i & ~fault_i;

  mdc_slot_timer #(
    .SLOT_CLKS (SLOT_CLKS),
    .NUM_SLOTS (NUM_SLOTS),
    .FAST_SLOTS(FAST_SLOTS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .start_o(period_start),
    .fast_o (fast_win)
  );

  mdc_decay_fsm #(
    .SENSE_CLKS(SENSE_CLKS)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .start_i(period_start),
    .fast_i (fast_win),
    .trip_i (trip_i),
    .zero_i (zero_i),
    .mode_o (mode)
  );

  assign gate_req = gate_encode(mode, neg_i);

  mdc_dead_band #(
    .DEAD_CLKS(DEAD_CLKS)
  ) u_dead (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .req_i (gate_req),
    .gate_o(gate_out)
  );

  assign u1_o = gate_out.u1;
  assign u2_o = gate_out.u2;
  assign l1_o = gate_out.l1;
  assign l2_o = gate_out.l2;

endmodule

// File: rtl/mixed_decay_chopper_chk.sv
module mixed_decay_chopper_chk #(
  parameter int unsigned DEAD_CLKS = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic fault_i,
  input logic u1_o,
  input logic u2_o,
  input logic l1_o,
  input logic l2_o
);

  localparam int unsigned DW = $clog2(DEAD_CLKS + 1);

  logic [3:0]    g;
  logic [DW-1:0] off_run_q;
  logic [3:0]    last_on_q;

  assign g = {u1_o, u2_o, l1_o, l2_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_run_q <= '0;
      last_on_q <= '0;
    end else if (g == 4'b0000) begin
      if (off_run_q != DW'(DEAD_CLKS)) off_run_q <= off_run_q + 1'b1;
    end else begin
      off_run_q <= '0;
      last_on_q <= g;
    end
  end

  // R10
  forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || fault_i) |-> (g == 4'b0000));

  // R12
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((u1_o && l1_o) || (u2_o && l2_o)));

  // R7
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g == 4'b0000) || (g == 4'b1001) || (g == 4'b0011) || (g == 4'b0110));

  // R9
  no_direct_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g != 4'b0000) |=> ((g == 4'b0000) || (g == $past(g))));

  // R9
  dead_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((g != 4'b0000) && (last_on_q != 4'b0000) && (g != last_on_q)) |->
      (off_run_q == DW'(DEAD_CLKS)));

endmodule

bind mixed_decay_chopper mixed_decay_chopper_chk #(
  .DEAD_CLKS(DEAD_CLKS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .fault_i(fault_i),
  .u1_o   (u1_o),
  .u2_o   (u2_o),
  .l1_o   (l1_o),
  .l2_o   (l2_o)
);

// File: tb/mixed_decay_chopper_test.sv
`timescale 1ns/1ps
module mixed_decay_chopper_test;

  localparam int SLOT  = 20;
  localparam int NSL   = 5;
  localparam int NFST  = 2;
  localparam int SENSE = 20;
  localparam int DEAD  = 12;
  localparam int P     = SLOT * NSL;
  localparam int MDT   = (NSL - NFST) * SLOT;

  localparam logic [3:0] CHG_P = 4'b1001;
  localparam logic [3:0] SLW   = 4'b0011;
  localparam logic [3:0] FST_P = 4'b0110;
  localparam logic [3:0] CHG_N = 4'b0110;
  localparam logic [3:0] FST_N = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fault = 1'b0, trip = 1'b0, neg = 1'b0, zero = 1'b0;
  logic u1, u2, l1, l2;
  logic [3:0] gv;
  assign gv = {u1, u2, l1, l2};

  always #2 clk = ~clk;

  mixed_decay_chopper #(
    .SLOT_CLKS(SLOT), .NUM_SLOTS(NSL), .FAST_SLOTS(NFST),
    .SENSE_CLKS(SENSE), .DEAD_CLKS(DEAD)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault), .trip_i(trip),
    .neg_i(neg), .zero_i(zero), .u1_o(u1), .u2_o(u2), .l1_o(l1), .l2_o(l2)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit c_en = 0, c_fault = 0, c_neg = 0, c_zero = 0, rnd_on = 0;
  int trip_at = P;
  string tag = "R1";

  // reference model state
  int rpos = 0, rmode = 0, rchg = 0, rdead = 0;
  logic [3:0] rapp = 4'b0000;

  function automatic logic [3:0] enc(int m, logic n);
    case (m)
      1: return n ? CHG_N : CHG_P;
      2: return SLW;
      3: return n ? FST_N : FST_P;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(posedge clk) begin : ref_model
    bit act, ps, fw;
    int nmode;
    logic [3:0] req;
    if (!rst_n) begin
      rpos = 0; rmode = 0; rchg = 0; rdead = 0; rapp = 4'b0000;
    end else begin
      act = en && !fault;
      ps  = act && (rpos == 0);
      fw  = (rpos >= MDT);
      if (!act)       nmode = 0;
      else if (zero)  nmode = 2;
      else if (ps)    nmode = 1;
      else case (rmode)
        0: nmode = 1;
        1: nmode = (trip && rchg >= SENSE - 1) ? (fw ? 3 : 2) : 1;
        2: nmode = fw ? 3 : 2;
        default: nmode = 3;
      endcase
      req = enc(rmode, neg);
      if (req != rapp) begin rapp = req; rdead = DEAD; end
      else if (rdead > 0) rdead--;
      rchg = (rmode == 1) ? ((rchg >= SENSE - 1) ? rchg : rchg + 1) : 0;
      rpos = !act ? 0 : ((rpos == P - 1) ? 0 : rpos + 1);
      rmode = nmode;
    end
  end

  // compare, then drive the next cycle's inputs
  always @(negedge clk) begin : drive
    logic [3:0] exp;
    string t;
    if (rst_n) begin
      exp = (en && !fault) ? ((rdead != 0) ? 4'b0000 : rapp) : 4'b0000;
      if (!(en && !fault)) t = "R10";
      else if (exp == 4'b0000) t = "R9";
      else if (zero) t = "R11";
      else t = tag;
      check(t, gv, exp);
      check("R12", {2'b00, u1 & l1, u2 & l2}, 4'b0000);
    end
    if (rnd_on && rpos == 0) begin
      trip_at = $urandom_range(0, P);
      if ($urandom_range(0, 3) == 0) c_neg = ~c_neg;
      c_zero  = ($urandom_range(0, 7) == 0);
      c_fault = ($urandom_range(0, 15) == 0);
      tag = c_neg ? "R8" : "R7";
    end
    en = c_en; fault = c_fault; neg = c_neg; zero = c_zero;
    trip = (rpos >= trip_at);
  end

  task automatic rise_of(input logic [3:0] v, output int t);
    logic [3:0] prev;
    prev = gv;
    t = -1;
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk); #1;
      if (gv == v && prev != v) begin t = cyc; return; end
      prev = gv;
    end
  endtask

  // wait for v to appear, then for it to end; count off cycles before the next vector
  task automatic leave(input logic [3:0] v, output int zeros, output logic [3:0] nv);
    int t;
    rise_of(v, t);
    zeros = 0;
    nv = 4'b0000;
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk); #1;
      if (gv != v) break;
    end
    for (int n = 0; n < 2000; n++) begin
      if (gv != 4'b0000) begin nv = gv; return; end
      zeros++;
      @(posedge clk); #1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int t0, t1, z, cnt, c0;
    logic [3:0] nv;
    void'($urandom(32'h5eed_0042));
    #1;
    check("R1", gv, 4'b0000);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R1", gv, 4'b0000);

    // early trip, positive current
    tag = "R7"; trip_at = 30; c_en = 1;
    repeat (P) @(posedge clk);
    rise_of(CHG_P, t0); rise_of(CHG_P, t1);
    check_int("R2", t1 - t0, P);
    rise_of(CHG_P, t0); rise_of(FST_P, t1);
    check_int("R3", t1 - t0, MDT);
    leave(CHG_P, z, nv);
    check("R4", nv, SLW);
    check_int("R9", z, DEAD);
    leave(SLW, z, nv);
    check("R7", nv, FST_P);
    check_int("R9", z, DEAD);

    // trip after the mixed-decay point
    tag = "R5"; trip_at = 75;
    repeat (P) @(posedge clk);
    leave(CHG_P, z, nv);
    check("R5", nv, FST_P);

    // comparator already high at period start
    tag = "R6"; trip_at = 0;
    repeat (2 * P) @(posedge clk);
    rise_of(CHG_P, t0);
    cnt = 1;
    for (int n = 0; n < P; n++) begin
      @(posedge clk); #1;
      if (gv != CHG_P) break;
      cnt++;
    end
    check_int("R6", cnt, SENSE - DEAD);
    check("R6", gv, 4'b0000);

    // negative current
    tag = "R8"; trip_at = 30; c_neg = 1;
    repeat (P) @(posedge clk);
    leave(CHG_N, z, nv);
    check("R8", nv, SLW);
    leave(SLW, z, nv);
    check("R8", nv, FST_N);

    // zero set-point
    tag = "R11"; c_zero = 1;
    repeat (P) @(posedge clk);
    cnt = 0;
    for (int n = 0; n < P; n++) begin
      @(posedge clk); #1;
      if (gv != SLW) cnt++;
    end
    check_int("R11", cnt, 0);
    c_zero = 0; c_neg = 0;

    // forced off and restart timing
    tag = "R10"; trip_at = 30;
    repeat (P + 7) @(posedge clk); #1;
    c_fault = 1;
    @(posedge clk); #1;
    check("R10", gv, 4'b0000);
    repeat (10) @(posedge clk); #1;
    c_fault = 0; c0 = cyc;
    rise_of(CHG_P, t0);
    check_int("R10", t0 - c0, DEAD + 2);
    repeat (37) @(posedge clk); #1;
    c_en = 0;
    @(posedge clk); #1;
    check("R10", gv, 4'b0000);
    repeat (5) @(posedge clk); #1;
    c_en = 1;

    // random mix
    rnd_on = 1;
    repeat (120 * P) @(posedge clk);
    rnd_on = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule